// File: doc/BRIEF.md
# Rotate and Logical Right Shift Unit

This combinational datapath slice serves the right-shift lane of a 64-bit integer core. It takes the instruction word, the two source operand values and the core's 64-bit mode enable. It returns one 64-bit result in the same evaluation, with no register stage.

Each shift function code has a rotate twin, and one spare instruction bit chooses between them. For the forms with an immediate amount, that spare bit is bit 21 of the instruction. For the forms with a register amount, it is bit 6. The word-sized forms act only on the low half of the `rt` operand, and their 32-bit answer is sign-extended into the full result. The doubleword forms act on all 64 bits and are legal only while 64-bit mode is on. If one of them arrives with the mode off, the unit raises an illegal flag and forces the result to zero, so the trap logic upstream can take over. Only the function field, `instr_i[5:0]`, is decoded. Selecting the opcode belongs to the surrounding decoder.

Top module: `rotshift_unit`

## Requirements
- R1: Function 0x02 with `instr_i[21]`=0 shifts `rt_i[31:0]` right logically by `instr_i[10:6]`. The 32-bit result is sign-extended from its bit 31, so any nonzero amount gives zeros in `result_o[63:31]`.
- R2: Function 0x02 with `instr_i[21]`=1 rotates `rt_i[31:0]` right by `instr_i[10:6]`. The result is sign-extended from bit 31.
- R3: Function 0x06 takes its amount from `rs_i[4:0]`, and `rs_i[63:5]` is ignored. `instr_i[6]`=1 selects a 32-bit rotate and `instr_i[6]`=0 selects a 32-bit logical shift.
- R4: The 32-bit forms (functions 0x02 and 0x06) ignore `rt_i[63:32]`, and `result_o[63:32]` always equals 32 copies of `result_o[31]`.
- R5: Function 0x3A shifts all 64 bits of `rt_i` right by `instr_i[10:6]`. It rotates when `instr_i[21]`=1 and shifts logically otherwise.
- R6: Function 0x3E works like R5 with an amount of `instr_i[10:6]`+32.
- R7: Function 0x16 takes a 64-bit amount from `rs_i[5:0]`, and `rs_i[63:6]` is ignored. `instr_i[6]`=1 selects a rotate and `instr_i[6]`=0 selects a logical shift.
- R8: A rotate by zero returns the operand unchanged. For the 32-bit forms this means the sign-extended low word.
- R9: With `mode64_en_i`=0, functions 0x3A, 0x3E and 0x16 drive `illegal_o`=1 and `result_o`=0, while the 32-bit forms still work. `illegal_o` is 0 in every other case.
- R10: Any other function code gives `result_o`=0 and `illegal_o`=0. The opcode field `instr_i[31:26]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word: function, amount field, rotate-select bits |
| rs_i | input | 64 | Register amount source for the variable forms |
| rt_i | input | 64 | Operand to shift or rotate |
| mode64_en_i | input | 1 | Core is in 64-bit mode; doubleword forms allowed |
| result_o | output | 64 | Shift or rotate result |
| illegal_o | output | 1 | Doubleword form used with 64-bit mode off |

## Verification
The unit is purely combinational, so any fault in its decoded operation shows at the ports in the same evaluation as the offending instruction. A wrong rotate-select bit makes the wrapped-around bits vanish, or makes them appear in a logical shift. An amount field taken from the wrong slice moves every bit of the result. A broken word-form path shows as upper-half bits that do not follow bit 31. For these reasons the amount sweeps use operands whose bits at the wrap boundary are set. A stuck illegal path shows either as a nonzero result beside a raised flag or as a doubleword answer while 64-bit mode is off.

// File: rtl/rotshift_pkg.sv
package rotshift_pkg;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned HALF    = XLEN / 2;
  localparam int unsigned AMT_W   = $clog2(XLEN);
  localparam int unsigned HAMT_W  = $clog2(HALF);
  localparam int unsigned FUNC_W  = 6;
  localparam int unsigned SA_LSB  = 6;
  localparam int unsigned IMM_ROT = 21;  // rotate select for immediate forms
  localparam int unsigned VAR_ROT = 6;   // rotate select for variable forms

  typedef enum logic [FUNC_W-1:0] {
    FN_W_IMM  = 6'h02,
    FN_W_VAR  = 6'h06,
    FN_D_VAR  = 6'h16,
    FN_D_IMM  = 6'h3A,
    FN_D_IMMH = 6'h3E
  } fn_e;

  typedef struct packed {
    logic             hit;
    logic             wide;
    logic             rotate;
    logic [AMT_W-1:0] amt;
  } op_t;
endpackage

// File: rtl/rotshift_decode.sv
module rotshift_decode
  import rotshift_pkg::*;
(
  input  logic [31:0]      instr_i,
  input  logic [AMT_W-1:0] rs_amt_i,
  output op_t              op_o
);
  logic [HAMT_W-1:0] sa;
  assign sa = instr_i[SA_LSB +: HAMT_W];

  always_comb begin
    op_o = '0;
    unique case (instr_i[FUNC_W-1:0])
      FN_W_IMM: begin
        op_o.hit    = 1'b1;
        op_o.rotate = instr_i[IMM_ROT];
        op_o.amt    = {1'b0, sa};
      end
      FN_W_VAR: begin
        op_o.hit    = 1'b1;
        op_o.rotate = instr_i[VAR_ROT];
        op_o.amt    = {1'b0, rs_amt_i[HAMT_W-1:0]};
      end
      FN_D_IMM: begin
        op_o.hit    = 1'b1;
        op_o.wide   = 1'b1;
        op_o.rotate = instr_i[IMM_ROT];
        op_o.amt    = {1'b0, sa};
      end
      FN_D_IMMH: begin
        op_o.hit    = 1'b1;
        op_o.wide   = 1'b1;
        op_o.rotate = instr_i[IMM_ROT];
        op_o.amt    = {1'b1, sa};  // amount + half width
      end
      FN_D_VAR: begin
        op_o.hit    = 1'b1;
        op_o.wide   = 1'b1;
        op_o.rotate = instr_i[VAR_ROT];
        op_o.amt    = rs_amt_i;
      end
      default: op_o = '0;
    endcase
  end
endmodule

// File: rtl/rotshift_rotr.sv
module rotshift_rotr #(
  parameter int unsigned W = 64,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          rotate_i,
  output logic [W-1:0]  q_o
);
  // Upper copy supplies the wrapped bits; zeros give a logical shift.
  logic [2*W-1:0] ext;
  logic [2*W-1:0] shifted;
  assign ext     = {(rotate_i ? data_i : {W{1'b0}}), data_i};
  assign shifted = ext >> amt_i;
  assign q_o     = shifted[W-1:0];
endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit
  import rotshift_pkg::*;
(
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic            mode64_en_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  op_t             op;
  logic [HALF-1:0] q_w;
  logic [XLEN-1:0] q_d;

  rotshift_decode u_dec (
    .instr_i  (instr_i),
    .rs_amt_i (rs_i[AMT_W-1:0]),
    .op_o     (op)
  );

  rotshift_rotr #(.W(HALF)) u_rot_w (
    .data_i   (rt_i[HALF-1:0]),
    .amt_i    (op.amt[HAMT_W-1:0]),
    .rotate_i (op.rotate),
    .q_o      (q_w)
  );

  rotshift_rotr #(.W(XLEN)) u_rot_d (
    .data_i   (rt_i),
    .amt_i    (op.amt),
    .rotate_i (op.rotate),
    .q_o      (q_d)
  );

  assign illegal_o = op.hit & op.wide & ~mode64_en_i;

  always_comb begin
    if (!op.hit || illegal_o) result_o = '0;
    else if (op.wide)         result_o = q_d;
    else                      result_o = {{(XLEN-HALF){q_w[HALF-1]}}, q_w};
  end
endmodule

// File: rtl/rotshift_chk.sv
module rotshift_chk
  import rotshift_pkg::*;
(
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs_i,
  input logic [XLEN-1:0] rt_i,
  input logic            mode64_en_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  logic [FUNC_W-1:0] fn;
  logic is_w, is_d, rot_sel;
  assign fn      = instr_i[FUNC_W-1:0];
  assign is_w    = (fn == 6'h02) || (fn == 6'h06);
  assign is_d    = (fn == 6'h3A) || (fn == 6'h3E) || (fn == 6'h16);
  assign rot_sel = (fn == 6'h06 || fn == 6'h16) ? instr_i[VAR_ROT] : instr_i[IMM_ROT];

  always_comb begin
    p_illegal_zero_r9: assert (!illegal_o || result_o == '0)
      else $error("illegal flag with nonzero result");
    p_illegal_mode_r9: assert (!illegal_o || (!mode64_en_i && is_d))
      else $error("illegal flag outside a doubleword form in 32-bit mode");
    p_sext_r4: assert (!is_w || result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}})
      else $error("word form result not sign-extended");
    p_srl_top_r1: assert (!(fn == 6'h02 && !instr_i[IMM_ROT] && instr_i[10:6] != 5'd0)
                          || result_o[XLEN-1:HALF-1] == '0)
      else $error("word logical shift left high bits set");
    p_rot_bits_r2: assert (!(is_w && rot_sel)
                           || $countones(result_o[HALF-1:0]) == $countones(rt_i[HALF-1:0]))
      else $error("word rotate lost bits");
    p_rot_bits_r7: assert (!(is_d && rot_sel && mode64_en_i)
                           || $countones(result_o) == $countones(rt_i))
      else $error("doubleword rotate lost bits");
    p_unknown_r10: assert (is_w || is_d || (result_o == '0 && !illegal_o))
      else $error("unhandled function produced output");
  end
endmodule

bind rotshift_unit rotshift_chk u_chk (
  .instr_i     (instr_i),
  .rs_i        (rs_i),
  .rt_i        (rt_i),
  .mode64_en_i (mode64_en_i),
  .result_o    (result_o),
  .illegal_o   (illegal_o)
);

// File: tb/rotshift_unit_tb_top.sv
module rotshift_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [63:0] rs, rt, result;
  logic        m64, illegal;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rotshift_unit dut_i (
    .instr_i     (instr),
    .rs_i        (rs),
    .rt_i        (rt),
    .mode64_en_i (m64),
    .result_o    (result),
    .illegal_o   (illegal)
  );

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] rsv;
    logic [63:0] rtv;
    logic        mode;
    logic [63:0] exp_res;
    logic        exp_ill;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h00000102, 64'h0, 64'hFFFFFFFF_80000010, 1'b1, 64'h00000000_08000001, 1'b0}, // R1 R4
    '{32'h00200102, 64'h0, 64'h12345678_8000001F, 1'b1, 64'hFFFFFFFF_F8000001, 1'b0}, // R2
    '{32'h00200002, 64'h0, 64'h00000000_9ABCDEF0, 1'b1, 64'hFFFFFFFF_9ABCDEF0, 1'b0}, // R8
    '{32'h00000046, 64'hFFFFFFFF_FFFFFFE8, 64'h00000000_12345678, 1'b1, 64'h00000000_78123456, 1'b0}, // R3
    '{32'h00000006, 64'h00000000_00000028, 64'h00000000_F0000000, 1'b1, 64'h00000000_00F00000, 1'b0}, // R3
    '{32'h0000013A, 64'h0, 64'hF0000000_000000AB, 1'b1, 64'h0F000000_0000000A, 1'b0}, // R5
    '{32'h0020023A, 64'h0, 64'h01234567_89ABCDEF, 1'b1, 64'hEF012345_6789ABCD, 1'b0}, // R5
    '{32'h0000013E, 64'h0, 64'hABCD1234_00000000, 1'b1, 64'h00000000_0ABCD123, 1'b0}, // R6
    '{32'h0020003E, 64'h0, 64'h01234567_89ABCDEF, 1'b1, 64'h89ABCDEF_01234567, 1'b0}, // R6
    '{32'h0020023E, 64'h0, 64'h01234567_89ABCDEF, 1'b1, 64'h6789ABCD_EF012345, 1'b0}, // R6
    '{32'h00000016, 64'hFFFFFFFF_FFFFFFC4, 64'h80000000_00000000, 1'b1, 64'h08000000_00000000, 1'b0}, // R7
    '{32'h00000056, 64'h00000000_0000003C, 64'h01234567_89ABCDEF, 1'b1, 64'h12345678_9ABCDEF0, 1'b0}, // R7
    '{32'h00000056, 64'h00000000_00000040, 64'hDEADBEEF_00000001, 1'b1, 64'hDEADBEEF_00000001, 1'b0}, // R8
    '{32'h0020023A, 64'h0, 64'h01234567_89ABCDEF, 1'b0, 64'h0, 1'b1}, // R9
    '{32'h00000102, 64'h0, 64'h00000000_000000F0, 1'b0, 64'h00000000_0000000F, 1'b0}, // R9
    '{32'h00000056, 64'h3, 64'h01234567_89ABCDEF, 1'b0, 64'h0, 1'b1}, // R9
    '{32'h00000103, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b1, 64'h0, 1'b0}, // R10
    '{32'hFC000102, 64'h0, 64'h00000000_00000100, 1'b1, 64'h00000000_00000010, 1'b0}, // R10
    '{32'h00000002, 64'h0, 64'h00000000_80000000, 1'b1, 64'hFFFFFFFF_80000000, 1'b0}  // R1 R4
  };

  task automatic check(input string tag, input logic [63:0] act_r, input logic [63:0] exp_r,
                       input logic act_i, input logic exp_i);
    checks++;
    if (act_r !== exp_r || act_i !== exp_i) begin
      fails++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, act_r, act_i, exp_r, exp_i);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [63:0] s, input logic [63:0] t,
                       input logic m);
    @(negedge clk);
    instr = i; rs = s; rt = t; m64 = m;
    #1;
  endtask

  function automatic logic [63:0] rot64(input logic [63:0] x, input int n);
    return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
  endfunction

  function automatic logic [63:0] rot32_sx(input logic [31:0] x, input int n);
    logic [31:0] r;
    r = (n == 0) ? x : ((x >> n) | (x << (32 - n)));
    return {{32{r[31]}}, r};
  endfunction

  initial begin
    instr = '0; rs = '0; rt = '0; m64 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle inputs: function 0 is unhandled (R10)
    apply(32'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    check("R10 idle", result, 64'h0, illegal, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].ins, VECS[k].rsv, VECS[k].rtv, VECS[k].mode);
      check($sformatf("table[%0d] R1..R10", k), result, VECS[k].exp_res, illegal, VECS[k].exp_ill);
    end

    // R7 R8: doubleword variable rotate over every amount, upper rs bits noisy
    for (int n = 0; n < 64; n++) begin
      apply(32'h00000056, {58'h2AAAAAAAAAAAAAA, 6'(n)}, 64'h8000_0000_0000_0001, 1'b1);
      check($sformatf("R7 drotrv n=%0d", n), result, rot64(64'h8000_0000_0000_0001, n),
            illegal, 1'b0);
    end

    // R2 R4: word immediate rotate over every amount, noisy rt upper half
    for (int n = 0; n < 32; n++) begin
      apply(32'h00200002 | (32'(n) << 6), 64'h0, 64'h5555_5555_8000_0001, 1'b1);
      check($sformatf("R2 rotr n=%0d", n), result, rot32_sx(32'h8000_0001, n), illegal, 1'b0);
    end

    // R6: logical form at amount 63 leaves only the top bit
    apply(32'h000007FE, 64'h0, 64'h8000_0000_0000_0000, 1'b1);
    check("R6 dsrl32 max", result, 64'h1, illegal, 1'b0);

    // R9: dsrl32 with mode off
    apply(32'h0000013E, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check("R9 dsrl32 mode off", result, 64'h0, illegal, 1'b1);

    // R3: bit 6 clear keeps srlv a shift even with rs upper bits set
    apply(32'h00000006, 64'hFFFF_FFFF_FFFF_FFE1, 64'h0000_0000_0000_0001, 1'b0);
    check("R3 srlv low bit out", result, 64'h0, illegal, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule